// File: doc/BRIEF.md
# Data Memory Effective Address Generator

This block forms the 12-bit data memory address used by byte- and bit-oriented instructions of an 8-bit microcontroller core. It takes the 8-bit file operand from the instruction, a one-bit select that chooses banked addressing, a 4-bit bank number, a 12-bit index pointer and an enable for the extended instruction set. From these it picks one of three ways of reading the operand and registers the resulting address together with a code that names the mode chosen.

In banked mode the bank number supplies the upper nibble. With the select clear, the operand normally addresses a shared window. That window splits into general-purpose RAM at the bottom of memory and special function registers at the top. When the extended set is enabled, the select is clear and the operand is small enough, the operand is instead taken as an offset from the index pointer. The decoder presents a request with a one-cycle valid strobe and reads the address on the next cycle.

Top module: `dm_addr_gen`

## Requirements
- R1: A synchronous reset clears the address output and the mode output to 0.
- R2: With `banked` = 1, the address is {`bank_sel`, `operand`} and the mode is 0. This holds with `ext_en` at either value.
- R3: With `banked` = 0, `ext_en` = 0 and `operand` ≤ 0x5F, the address is the operand zero-extended (0x000–0x05F) and the mode is 1.
- R4: With `banked` = 0 and `operand` ≥ 0x60, the address is 0xF00 | `operand` (0xF60–0xFFF) and the mode is 1. This holds with `ext_en` at either value.
- R5: With `banked` = 0, `ext_en` = 1 and `operand` ≤ 0x5F, the address is (`idx_ptr` + `operand`) mod 4096 and the mode is 2.
- R6: Operand 0x5F is the highest offset that selects indexed mode. Operand 0x60 always selects the window.
- R7: The outputs take the new values on the first rising edge at which `vld_in` = 1, one cycle of latency. They hold their values while `vld_in` = 0.
- R8: The mode output never takes the value 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| vld_in | input | 1 | Request strobe; the inputs are captured when it is high |
| operand | input | 8 | File operand field of the instruction |
| banked | input | 1 | 1 = banked direct, 0 = window or indexed |
| bank_sel | input | 4 | Bank number, used as the upper nibble in banked mode |
| idx_ptr | input | 12 | Base pointer for indexed mode |
| ext_en | input | 1 | Extended instruction set enable |
| ea_out | output | 12 | Registered effective address |
| mode_out | output | 2 | Registered mode: 0 banked, 1 window, 2 indexed |

## Verification
A wrong mode decision shows on `mode_out` and on the upper nibble of `ea_out` one cycle after the strobe. The cases that need watching are the operand at the 0x5F/0x60 edge and the `ext_en` and `banked` combinations. A faulty adder or carry shows as a wrong low byte or wrong wrap in indexed results, which appears once the pointer is near 0xFFF. A broken load enable shows as outputs that change in a cycle with no strobe. The bench checks the outputs in the cycle after every strobe and also in idle cycles.

// File: rtl/dm_addr_gen.sv
module dm_addr_gen #(
  parameter int ADDR_W   = 12,
  parameter int OP_W     = 8,
  parameter int BANK_W   = 4,
  parameter int IDX_LAST = 'h5F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld_in,
  input  logic [OP_W-1:0]   operand,
  input  logic              banked,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic [ADDR_W-1:0] idx_ptr,
  input  logic              ext_en,
  output logic [ADDR_W-1:0] ea_out,
  output logic [1:0]        mode_out
);
  localparam int HI_W = ADDR_W - OP_W;
  localparam logic [1:0] M_BANK = 2'd0, M_WIN = 2'd1, M_IDX = 2'd2;

  logic              low_op;
  logic              use_idx;
  logic [ADDR_W-1:0] win_addr, bank_addr, idx_addr, nxt_addr;
  logic [1:0]        nxt_mode;

  assign low_op    = operand <= OP_W'(IDX_LAST);
  assign use_idx   = !banked && ext_en && low_op;
  assign bank_addr = {bank_sel, operand};
  assign win_addr  = {{HI_W{!low_op}}, operand};
  assign idx_addr  = idx_ptr + {{HI_W{1'b0}}, operand};

  assign nxt_addr = banked ? bank_addr : (use_idx ? idx_addr : win_addr);
  assign nxt_mode = banked ? M_BANK : (use_idx ? M_IDX : M_WIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      ea_out   <= '0;
      mode_out <= M_BANK;
    end else if (vld_in) begin
      ea_out   <= nxt_addr;
      mode_out <= nxt_mode;
    end
  end
endmodule

// File: rtl/dm_addr_gen_chk.sv
module dm_addr_gen_chk (
  input logic        clk,
  input logic        rst,
  input logic        vld_in,
  input logic [7:0]  operand,
  input logic        banked,
  input logic [3:0]  bank_sel,
  input logic [11:0] idx_ptr,
  input logic        ext_en,
  input logic [11:0] ea_out,
  input logic [1:0]  mode_out
);
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (ea_out == 12'h000 && mode_out == 2'd0));

  p_banked_r2: assert property (@(posedge clk) disable iff (rst)
    (vld_in && banked) |=> (ea_out == {$past(bank_sel), $past(operand)} && mode_out == 2'd0));

  p_low_window_r3: assert property (@(posedge clk) disable iff (rst)
    (vld_in && !banked && !ext_en && operand <= 8'h5F) |=> (ea_out == {4'h0, $past(operand)} && mode_out == 2'd1));

  p_high_window_r4: assert property (@(posedge clk) disable iff (rst)
    (vld_in && !banked && operand >= 8'h60) |=> (ea_out == {4'hF, $past(operand)} && mode_out == 2'd1));

  p_indexed_r5: assert property (@(posedge clk) disable iff (rst)
    (vld_in && !banked && ext_en && operand <= 8'h5F) |=>
      (ea_out == 12'($past(idx_ptr) + {4'h0, $past(operand)}) && mode_out == 2'd2));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !vld_in |=> ($stable(ea_out) && $stable(mode_out)));

  p_mode_legal_r8: assert property (@(posedge clk) disable iff (rst) mode_out != 2'd3);
endmodule

bind dm_addr_gen dm_addr_gen_chk u_chk (
  .clk(clk), .rst(rst), .vld_in(vld_in), .operand(operand), .banked(banked),
  .bank_sel(bank_sel), .idx_ptr(idx_ptr), .ext_en(ext_en),
  .ea_out(ea_out), .mode_out(mode_out)
);

// File: tb/dm_addr_gen_test.sv
module dm_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        vld_in = 1'b0;
  logic [7:0]  operand = '0;
  logic        banked = 1'b0;
  logic [3:0]  bank_sel = '0;
  logic [11:0] idx_ptr = '0;
  logic        ext_en = 1'b0;
  logic [11:0] ea_out;
  logic [1:0]  mode_out;

  int checks = 0;
  int errors = 0;
  logic [11:0] exp_ea = '0;
  logic [1:0]  exp_md = '0;

  dm_addr_gen uut (.*);

  always #10 clk = ~clk;

  function automatic logic [11:0] ref_ea(logic [7:0] op, logic bk, logic [3:0] bs,
                                         logic [11:0] ip, logic ex);
    if (bk) return {bs, op};
    if (ex && op <= 8'h5F) return 12'(ip + 12'(op));
    return (op >= 8'h60) ? {4'hF, op} : {4'h0, op};
  endfunction

  function automatic logic [1:0] ref_md(logic [7:0] op, logic bk, logic ex);
    if (bk) return 2'd0;
    if (ex && op <= 8'h5F) return 2'd2;
    return 2'd1;
  endfunction

  task automatic check(string req);
    checks++;
    if (ea_out !== exp_ea || mode_out !== exp_md) begin
      errors++;
      $display("FAIL %s: ea=%h mode=%0d expected ea=%h mode=%0d", req, ea_out, mode_out, exp_ea, exp_md);
    end
  endtask

  task automatic issue(logic [7:0] op, logic bk, logic [3:0] bs, logic [11:0] ip,
                       logic ex, string req);
    operand = op; banked = bk; bank_sel = bs; idx_ptr = ip; ext_en = ex; vld_in = 1'b1;
    @(negedge clk);
    vld_in = 1'b0;
    exp_ea = ref_ea(op, bk, bs, ip, ex);
    exp_md = ref_md(op, bk, ex);
    check(req);
    if (exp_md == 2'd3) begin errors++; $display("FAIL R8: reference mode 3"); end
  endtask

  initial begin
    #4000000;
    errors++; checks++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    exp_ea = '0; exp_md = '0;
    check("R1 reset state");

    issue(8'h34, 1'b1, 4'h7, 12'h123, 1'b0, "R2 banked ext off");
    issue(8'h12, 1'b1, 4'hA, 12'h800, 1'b1, "R2 banked ext on");
    issue(8'h20, 1'b0, 4'h3, 12'h400, 1'b0, "R3 low window");
    issue(8'h5F, 1'b0, 4'h3, 12'h400, 1'b0, "R3 window top 5F");
    issue(8'h60, 1'b0, 4'h3, 12'h400, 1'b0, "R4 window SFR ext off");
    issue(8'hFF, 1'b0, 4'h3, 12'h400, 1'b1, "R4 window SFR ext on");
    issue(8'h10, 1'b0, 4'h3, 12'h400, 1'b1, "R5 indexed");
    issue(8'h5F, 1'b0, 4'h0, 12'hFF0, 1'b1, "R5 indexed wrap");
    issue(8'h5F, 1'b0, 4'h0, 12'h100, 1'b1, "R6 offset 5F indexed");
    issue(8'h60, 1'b0, 4'h0, 12'h100, 1'b1, "R6 offset 60 window");

    for (int k = 0; k < 3; k++) begin
      operand = 8'(k * 37); banked = 1'b0; ext_en = 1'b1; idx_ptr = 12'hABC;
      @(negedge clk);
      check("R7 hold without strobe");
    end

    rst = 1'b1; vld_in = 1'b1;
    @(negedge clk);
    rst = 1'b0; vld_in = 1'b0;
    exp_ea = '0; exp_md = '0;
    check("R1 reset over strobe");

    for (int i = 0; i < 400; i++) begin
      logic [7:0] op;
      op = 8'($urandom);
      if ($urandom % 4 == 0) op = 8'h5E + 8'($urandom % 4);
      issue(op, 1'($urandom), 4'($urandom), 12'($urandom), 1'($urandom), "R2-R8 random");
      if ($urandom % 3 == 0) begin
        operand = 8'($urandom); idx_ptr = 12'($urandom);
        @(negedge clk);
        check("R7 random idle hold");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule